// File: doc/BRIEF.md
# Virtual Processor Run Controller

This block keeps the run or suspend state of every virtual processor on one core. Each virtual processor has one run-enable output. Software changes these outputs through a small register bus, which has an address, a write enable, write data and combinational read data.

Software sets and clears the run state through two separate write-only registers. Each register takes a bitmask with one bit per virtual processor. A third register is read-only and reports the current run mask. A parameter sets the state after reset: either only virtual processor 0 runs, or all virtual processors run. In the first case, software starts the other processors itself through the set register.

Top module: `vpc_ctrl`

## Requirements
- R1: A write to word address 0 (the start register) puts every virtual processor whose write-data bit is 1 into the run state. Bit i of the mask stands for processor i.
- R2: A write to word address 1 (the halt register) puts every virtual processor whose write-data bit is 1 into the suspend state.
- R3: In a start or halt write, a 0 bit leaves the matching processor in its previous state.
- R4: A read of word address 2 (the status register) returns the current run mask in bits NUM_VP-1:0. The result of a write shows from the first read after the clock edge that took that write.
- R5: Reads of the start register, the halt register and any unmapped address return 0.
- R6: Writes to the status register or to any unmapped address do not change the run mask.
- R7: With BOOT_ONLY_FIRST=1, only processor 0 is in the run state after reset.
- R8: With BOOT_ONLY_FIRST=0, all NUM_VP processors are in the run state after reset.
- R9: Write-data bits at or above NUM_VP are ignored, and status bits at or above NUM_VP always read 0.
- R10: run_en matches the run mask at all times. A write changes run_en at the same clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data (bitmask) |
| bus_rdata | output | DATA_W | Read data, combinational from address and state |
| run_en | output | NUM_VP | Run enable, one bit per virtual processor |

## Verification
A write takes effect on the clock edge that samples it, because one register stage sits between the bus and run_en. The bench drives the write on a falling edge, lets one rising edge pass, and then samples both run_en and the status readback on the following falling edge. Reads are combinational. The bench changes the address on a falling edge and samples bus_rdata half a cycle later, before any other edge. Reset values are checked in the first cycle after reset is released.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
    // Word offsets of the register slots
    localparam int unsigned VPC_OFS_START = 0;
    localparam int unsigned VPC_OFS_HALT  = 1;
    localparam int unsigned VPC_OFS_STAT  = 2;

    typedef enum logic [1:0] {
        SLOT_START = 2'd0,
        SLOT_HALT  = 2'd1,
        SLOT_STAT  = 2'd2,
        SLOT_NONE  = 2'd3
    } vpc_slot_e;

    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic stat_sel;
    } vpc_ctl_t;
endpackage

// File: rtl/vpc_decode.sv
module vpc_decode
    import vpc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output vpc_ctl_t          ctl
);
    vpc_slot_e slot;

    always_comb begin
        if (addr == ADDR_W'(VPC_OFS_START))      slot = SLOT_START;
        else if (addr == ADDR_W'(VPC_OFS_HALT))  slot = SLOT_HALT;
        else if (addr == ADDR_W'(VPC_OFS_STAT))  slot = SLOT_STAT;
        else                                     slot = SLOT_NONE;
    end

    always_comb begin
        ctl          = '0;
        ctl.set_en   = we && (slot == SLOT_START);
        ctl.clr_en   = we && (slot == SLOT_HALT);
        ctl.stat_sel = (slot == SLOT_STAT);
    end

    always_comb begin
        AST_ONE_STROBE: assert ($onehot0({ctl.set_en, ctl.clr_en, ctl.stat_sel})); // R6
    end
endmodule

// File: rtl/vpc_run_mask.sv
module vpc_run_mask #(
    parameter int unsigned NUM_VP          = 4,
    parameter bit          BOOT_ONLY_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [NUM_VP-1:0] mask,
    output logic [NUM_VP-1:0] run_q_o
);
    localparam logic [NUM_VP-1:0] ALL_ON   = {NUM_VP{1'b1}};
    localparam logic [NUM_VP-1:0] FIRST_ON = NUM_VP'(1);
    localparam logic [NUM_VP-1:0] RST_MASK = BOOT_ONLY_FIRST ? FIRST_ON : ALL_ON;

    typedef struct packed {
        logic [NUM_VP-1:0] run;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_VP-1:0] bit_next;

    // per-VP next-state cell
    for (genvar g = 0; g < NUM_VP; g++) begin : g_vp
        always_comb begin
            bit_next[g] = s_q.run[g];
            if (mask[g]) begin
                if (set_en)      bit_next[g] = 1'b1;
                else if (clr_en) bit_next[g] = 1'b0;
            end
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.run = bit_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{run: RST_MASK};
        else        s_q <= s_d;
    end

    assign run_q_o = s_q.run;

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((s_q.run & $past(mask)) == $past(mask))); // R1
    AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((s_q.run & $past(mask)) == '0)); // R2
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en || clr_en) |=> ((s_q.run & ~$past(mask)) == ($past(s_q.run) & ~$past(mask)))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(s_q.run)); // R6
endmodule

// File: rtl/vpc_rdmux.sv
module vpc_rdmux #(
    parameter int unsigned NUM_VP = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              stat_sel,
    input  logic [NUM_VP-1:0] run_q,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (stat_sel) rdata = DATA_W'(run_q);
    end

    always_comb begin
        AST_UPPER_ZERO: assert ((rdata >> NUM_VP) == '0); // R9
        if (!stat_sel) AST_NONSTAT_ZERO: assert (rdata == '0); // R5
    end
endmodule

// File: rtl/vpc_ctrl.sv
module vpc_ctrl
    import vpc_pkg::*;
#(
    parameter int unsigned NUM_VP          = 4,
    parameter int unsigned ADDR_W          = 4,
    parameter int unsigned DATA_W          = 32,
    parameter bit          BOOT_ONLY_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_VP-1:0] run_en
);
    localparam int unsigned HI_BITS = DATA_W - NUM_VP;

    vpc_ctl_t          ctl;
    logic [NUM_VP-1:0] run_q;

    if (HI_BITS > 0) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^bus_wdata[DATA_W-1:NUM_VP];
    end

    vpc_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .ctl  (ctl)
    );

    vpc_run_mask #(.NUM_VP(NUM_VP), .BOOT_ONLY_FIRST(BOOT_ONLY_FIRST)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ctl.set_en),
        .clr_en  (ctl.clr_en),
        .mask    (bus_wdata[NUM_VP-1:0]),
        .run_q_o (run_q)
    );

    vpc_rdmux #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) i_rd (
        .stat_sel (ctl.stat_sel),
        .run_q    (run_q),
        .rdata    (bus_rdata)
    );

    assign run_en = run_q;

    AST_WR_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != ADDR_W'(VPC_OFS_START) && bus_addr != ADDR_W'(VPC_OFS_HALT))
        |=> $stable(run_en)); // R6
    AST_STAT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(VPC_OFS_STAT)) |-> (bus_rdata == DATA_W'(run_en))); // R4
endmodule

// File: tb/test_vpc_ctrl.sv
module test_vpc_ctrl;
    localparam int unsigned NV = 4;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 32;
    localparam logic [NV-1:0] FULL = {NV{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_a, rd_b;
    logic [NV-1:0] en_a, en_b;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;
    logic [NV-1:0] exp_a, exp_b;

    always #5 clk = ~clk;

    vpc_ctrl #(.NUM_VP(NV), .ADDR_W(AW), .DATA_W(DW), .BOOT_ONLY_FIRST(1'b1)) i_vpc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rd_a), .run_en(en_a));

    vpc_ctrl #(.NUM_VP(NV), .ADDR_W(AW), .DATA_W(DW), .BOOT_ONLY_FIRST(1'b0)) i_vpc_ctrl_all (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rd_b), .run_en(en_b));

    function automatic logic [NV-1:0] model(logic [NV-1:0] m, logic [AW-1:0] a, logic [DW-1:0] d);
        logic [NV-1:0] k = d[NV-1:0];
        if (a == AW'(0)) return m | k;      // R1
        if (a == AW'(1)) return m & ~k;     // R2
        return m;                           // R6
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // write on a falling edge, one rising edge takes it, sample on next falling edge
    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, string req);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        exp_a = model(exp_a, a, d);
        exp_b = model(exp_b, a, d);
        check({req, " R10 run_en A"}, DW'(en_a), DW'(exp_a));
        check({req, " R10 run_en B"}, DW'(en_b), DW'(exp_b));
        addr = AW'(2);
        #2;
        check({req, " R4 status A"}, rd_a, DW'(exp_a));
        check({req, " R4 status B"}, rd_b, DW'(exp_b));
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        exp_a = NV'(1);
        exp_b = FULL;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R7 reset first only", DW'(en_a), DW'(NV'(1)));
        check("R8 reset all", DW'(en_b), DW'(FULL));
        addr = AW'(2); #2;
        check("R7 status after reset", rd_a, DW'(NV'(1)));
        check("R8 status after reset", rd_b, DW'(FULL));
        // R5 reads of write-only and unmapped slots
        @(negedge clk); addr = AW'(0); #2; check("R5 start reads 0", rd_a, '0);
        @(negedge clk); addr = AW'(1); #2; check("R5 halt reads 0", rd_b, '0);
        @(negedge clk); addr = AW'(9); #2; check("R5 unmapped reads 0", rd_a, '0);
        @(negedge clk);
        // directed corners
        do_write(AW'(0), 32'h0000_0006, "R1 start bits 1,2");
        do_write(AW'(0), 32'h0000_0000, "R3 zero start mask");
        do_write(AW'(1), 32'h0000_0002, "R2 halt bit 1");
        do_write(AW'(1), 32'h0000_0000, "R3 zero halt mask");
        do_write(AW'(2), 32'hFFFF_FFFF, "R6 status write");
        do_write(AW'(7), 32'hFFFF_FFFF, "R6 unmapped write");
        do_write(AW'(0), 32'hFFFF_FFF0, "R9 upper start bits");
        do_write(AW'(0), 32'hFFFF_FFFF, "R1 start all");
        do_write(AW'(1), 32'hFFFF_FFF0, "R9 upper halt bits");
        do_write(AW'(1), 32'hFFFF_FFFF, "R2 halt all");
        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int unsigned sel = $urandom_range(0, 9);
            logic [AW-1:0] a;
            logic [DW-1:0] d = $urandom;
            if (sel < 4)      a = AW'(0);
            else if (sel < 8) a = AW'(1);
            else if (sel < 9) a = AW'(2);
            else              a = AW'($urandom_range(3, 15));
            do_write(a, d, "R3 random");
            if (sel == 0) begin
                addr = AW'($urandom_range(0, 1)); #2;
                check("R5 random write-only read", rd_b, '0);
                @(negedge clk);
            end
        end
        finish_run();
    end
endmodule